// File: doc/BRIEF.md
# Disk Sequencer Microword Control Datapath

This block sits beside a microprogram sequencer on a disk controller card. Each time the sequencer's output address produces a fresh seven-byte microword, the block accepts it and holds it. From the held word it drives the sequencer's instruction code and branch-data value. It also advances three event counters when chosen microword bits rise from one microword to the next. Finally, it selects one of 32 candidate signals to form the sequencer's active-low condition input.

The same held word supplies the host status byte and the end-of-program request line. A host-issued panic reset is handled by a two-state machine. While the panic is pending, the instruction presented to the sequencer is forced to zero. The pending state ends once the next microword has been accepted.

The state machine has two states. `ST_RUN` passes the held instruction nibble through. `ST_PANIC` forces the instruction to zero. Transition *panic_enter* goes from `ST_RUN` to `ST_PANIC` on `panic_req`. Transition *panic_leave* goes from `ST_PANIC` to `ST_RUN` when a microword is accepted without `panic_req`. In every other case the state is kept.

Top module: `dseq_uword_path`

## Requirements
- R1: When `uw_valid` is high at a clock edge, `uword` is held. Byte k of the word is `uword[8k+7:8k]`. From the next cycle, `seq_data` equals byte 0. Outside a panic, `seq_instr` equals byte 1 bits 3:0.
- R2: In the cycle after `panic_req` is high, `seq_instr` reads 0. It keeps reading 0 until a microword is accepted in a cycle where `panic_req` is low. From the cycle after that acceptance it shows the held nibble again.
- R3: Three counters, each `CTR_W` bits wide and wrapping modulo 2^CTR_W, are exposed on ports. The line counter is clocked by byte 2 bit 1, the ED counter by byte 2 bit 3, and the head counter by byte 2 bit 5. A counter adds one only when an accepted microword has its clock bit at 1 and the previously held word had it at 0. Repeated ones, falling bits and cycles without `uw_valid` leave it unchanged.
- R4: The clear bits are byte 2 bit 2 (line), bit 4 (ED) and bit 6 (head). An accepted microword with its clear bit at 1 sets that counter to 0, and this takes priority over its clock bit.
- R5: The bank select is {byte 2 bit 0, byte 1 bit 7} and the bit select is byte 1 bits 6:4. `cond_n` is the inverse of the selected bit. Bank 0 holds the following, from bit 0 upward:
  - bits 1:0: entry `line_cnt[4:0]` of `line_lut`, where entry i is `line_lut[2i+1:2i]`;
  - bit 2: ED counter bit 2;
  - bit 3: head counter bit 0;
  - bit 4: a constant 0;
  - bits 7:5: `drive_stat` bits 0, 1 and 2 (ready, fault, on-cylinder).
- R6: Bank 1 is `drive_stat[10:3]`: seek error, index, sector, mark found, write-protect, selected, seek end and sync. Bank 2 is {`cmd_word[3:0]`, 3'b000, `drive_stat[11]`}, where bit 11 is RAM overflow. Bank 3 is `cmd_word[11:4]`.
- R7: `req_b` is the inverse of byte 3 bit 1 of the held word. Byte 3 bit 1 marks the end of the program.
- R8: `host_status` is {fault `drive_stat[1]`, ED counter bits 1:0, write-protect `drive_stat[7]`, ready `drive_stat[0]`, byte 6 bits 2:0}, listed from bit 7 down to bit 0.
- R9: A synchronous active-high `rst` clears the held word, all three counters and the panic state. After it, the outputs read: instruction 0, data 0, counters 0, `req_b` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uw_valid | input | 1 | A new microword is present on `uword` |
| uword | input | 56 | Microword; byte k is bits 8k+7:8k |
| panic_req | input | 1 | Host panic reset request |
| drive_stat | input | 12 | Drive status flags |
| cmd_word | input | 12 | Host command word |
| line_lut | input | 2*LUT_DEPTH | Two-bit lookup entries indexed by the line counter |
| seq_instr | output | 4 | Instruction code to the sequencer |
| seq_data | output | 8 | Branch data to the sequencer |
| cond_n | output | 1 | Active-low condition to the sequencer |
| req_b | output | 1 | End-of-program request |
| host_status | output | 8 | Packed status byte for the host |
| line_cnt | output | CTR_W | Line counter |
| ed_cnt | output | CTR_W | ED counter |
| head_cnt | output | CTR_W | Head counter |

## Verification
The checker takes two things about the inputs for granted. First, `uword` is stable and meaningful whenever `uw_valid` is high. Second, `rst` is a clean synchronous pulse, so the counter properties can compare against the held word of the previous acceptance.

The stimulus drives every input on the falling edge and holds `uw_valid` for exactly one cycle per microword. It keeps byte 2 at zero or bank-select only in words that are meant to steer the condition multiplexer, so a counter moves only where a test intends it. Panic requests are issued both alone and together with an accepted microword, to exercise both transitions of the state machine.

// File: rtl/dseq_pkg.sv
`timescale 1ns/1ps
package dseq_pkg;
    localparam int UW_BYTES = 7;
    localparam int UW_W     = 8 * UW_BYTES;
    localparam int STAT_W   = 12;
    localparam int CMD_W    = 12;
    localparam int NUM_CTR  = 3;
    localparam int BYTE2_LO = 16;

    // drive status bit positions
    localparam int DS_READY = 0;
    localparam int DS_FAULT = 1;
    localparam int DS_ONCYL = 2;
    localparam int DS_WPROT = 7;
    localparam int DS_RAMOV = 11;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_PANIC = 1'b1
    } seq_state_e;

    function automatic logic [7:0] uw_byte(input logic [UW_W-1:0] w, input int k);
        return w[8*k +: 8];
    endfunction
endpackage

// File: rtl/dseq_edge_ctr.sv
`timescale 1ns/1ps
module dseq_edge_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         bit_old,
    input  logic         bit_new,
    input  logic         clr_new,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (step) begin
            if (clr_new)
                count <= '0;
            else if (bit_new && !bit_old)
                count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dseq_cond_mux.sv
`timescale 1ns/1ps
module dseq_cond_mux
    import dseq_pkg::*;
(
    input  logic [1:0]        lut_bits,
    input  logic              ed_bit2,
    input  logic              head_bit0,
    input  logic [STAT_W-1:0] drive_stat,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [1:0]        bank_sel,
    input  logic [2:0]        bit_sel,
    output logic              cond_n
);
    logic [7:0] bank [4];

    always_comb begin
        bank[0] = {drive_stat[DS_ONCYL], drive_stat[DS_FAULT], drive_stat[DS_READY],
                   1'b0, head_bit0, ed_bit2, lut_bits};
        bank[1] = drive_stat[10:3];
        bank[2] = {cmd_word[3:0], 3'b000, drive_stat[DS_RAMOV]};
        bank[3] = cmd_word[11:4];
        cond_n  = ~bank[bank_sel][bit_sel];
    end
endmodule

// File: rtl/dseq_status_pack.sv
`timescale 1ns/1ps
module dseq_status_pack
    import dseq_pkg::*;
(
    input  logic [2:0]        code_bits,
    input  logic [1:0]        ed_low,
    input  logic [STAT_W-1:0] drive_stat,
    output logic [7:0]        host_status
);
    always_comb begin
        host_status = {drive_stat[DS_FAULT], ed_low, drive_stat[DS_WPROT],
                       drive_stat[DS_READY], code_bits};
    end
endmodule

// File: rtl/dseq_uword_path.sv
`timescale 1ns/1ps
module dseq_uword_path
    import dseq_pkg::*;
#(
    parameter int CTR_W     = 8,
    parameter int LUT_DEPTH = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   uw_valid,
    input  logic [UW_W-1:0]        uword,
    input  logic                   panic_req,
    input  logic [STAT_W-1:0]      drive_stat,
    input  logic [CMD_W-1:0]       cmd_word,
    input  logic [2*LUT_DEPTH-1:0] line_lut,
    output logic [3:0]             seq_instr,
    output logic [7:0]             seq_data,
    output logic                   cond_n,
    output logic                   req_b,
    output logic [7:0]             host_status,
    output logic [CTR_W-1:0]       line_cnt,
    output logic [CTR_W-1:0]       ed_cnt,
    output logic [CTR_W-1:0]       head_cnt
);
    localparam int LUT_AW = $clog2(LUT_DEPTH);

    seq_state_e      state_q, state_d;
    logic [UW_W-1:0] held_word;
    logic [7:0]      hb1, hb2, hb3, hb6;
    logic [CTR_W-1:0] cnt [NUM_CTR];
    logic [LUT_AW-1:0] lut_idx;
    logic [1:0]      lut_bits;
    logic            unused_bits;

    // microword holding register
    always_ff @(posedge clk) begin
        if (rst)
            held_word <= '0;
        else if (uw_valid)
            held_word <= uword;
    end

    assign hb1 = uw_byte(held_word, 1);
    assign hb2 = uw_byte(held_word, 2);
    assign hb3 = uw_byte(held_word, 3);
    assign hb6 = uw_byte(held_word, 6);
    assign unused_bits = ^{held_word[47:32], hb2[7:1], hb3[7:2], hb3[0], hb6[7:3]};

    // panic state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (panic_req) state_d = ST_PANIC;
            ST_PANIC: if (uw_valid && !panic_req) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        seq_instr = hb1[3:0];
        unique case (state_q)
            ST_RUN:   seq_instr = hb1[3:0];
            ST_PANIC: seq_instr = 4'h0;
            default:  seq_instr = 4'h0;
        endcase
    end

    assign seq_data = uw_byte(held_word, 0);
    assign req_b    = ~hb3[1];

    // event counters: clock bit 2k+1, clear bit 2k+2 of byte 2
    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        dseq_edge_ctr #(.W(CTR_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .step    (uw_valid),
            .bit_old (held_word[BYTE2_LO + 2*k + 1]),
            .bit_new (uword[BYTE2_LO + 2*k + 1]),
            .clr_new (uword[BYTE2_LO + 2*k + 2]),
            .count   (cnt[k])
        );
    end

    assign line_cnt = cnt[0];
    assign ed_cnt   = cnt[1];
    assign head_cnt = cnt[2];

    assign lut_idx  = line_cnt[LUT_AW-1:0];
    assign lut_bits = line_lut[2*lut_idx +: 2];

    dseq_cond_mux u_cond (
        .lut_bits   (lut_bits),
        .ed_bit2    (ed_cnt[2]),
        .head_bit0  (head_cnt[0]),
        .drive_stat (drive_stat),
        .cmd_word   (cmd_word),
        .bank_sel   ({hb2[0], hb1[7]}),
        .bit_sel    (hb1[6:4]),
        .cond_n     (cond_n)
    );

    dseq_status_pack u_stat (
        .code_bits   (hb6[2:0]),
        .ed_low      (ed_cnt[1:0]),
        .drive_stat  (drive_stat),
        .host_status (host_status)
    );
endmodule

// File: rtl/dseq_uword_checker.sv
`timescale 1ns/1ps
module dseq_uword_checker
    import dseq_pkg::*;
#(
    parameter int CTR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             uw_valid,
    input logic [UW_W-1:0]  uword,
    input logic             panic_req,
    input logic [3:0]       seq_instr,
    input logic [7:0]       seq_data,
    input logic             req_b,
    input logic [CTR_W-1:0] line_cnt,
    input logic [CTR_W-1:0] ed_cnt,
    input logic [CTR_W-1:0] head_cnt,
    input logic [7:0]       prev_b2
);
    AST_DATA_LATCH: assert property (@(posedge clk) disable iff (rst)
        uw_valid |=> seq_data == $past(uword[7:0])); // R1
    AST_INSTR_LATCH: assert property (@(posedge clk) disable iff (rst)
        (uw_valid && !panic_req) |=> seq_instr == $past(uword[11:8])); // R1
    AST_PANIC_FORCE: assert property (@(posedge clk) disable iff (rst)
        panic_req |=> seq_instr == 4'h0); // R2
    AST_CTR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !uw_valid |=> ($stable(line_cnt) && $stable(ed_cnt) && $stable(head_cnt))); // R3
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (uw_valid && !uword[18] && uword[17] && !prev_b2[1])
        |=> line_cnt == CTR_W'($past(line_cnt) + 1'b1)); // R3
    AST_LINE_NOEDGE: assert property (@(posedge clk) disable iff (rst)
        (uw_valid && !uword[18] && !(uword[17] && !prev_b2[1])) |=> $stable(line_cnt)); // R3
    AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (uw_valid && uword[18] && uword[20] && uword[22])
        |=> (line_cnt == '0 && ed_cnt == '0 && head_cnt == '0)); // R4
    AST_REQ_END: assert property (@(posedge clk) disable iff (rst)
        uw_valid |=> req_b == !$past(uword[25])); // R7
endmodule

bind dseq_uword_path dseq_uword_checker #(.CTR_W(CTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .uw_valid  (uw_valid),
    .uword     (uword),
    .panic_req (panic_req),
    .seq_instr (seq_instr),
    .seq_data  (seq_data),
    .req_b     (req_b),
    .line_cnt  (line_cnt),
    .ed_cnt    (ed_cnt),
    .head_cnt  (head_cnt),
    .prev_b2   (held_word[23:16])
);

// File: tb/dseq_uword_path_bench.sv
`timescale 1ns/1ps
module dseq_uword_path_bench;
    localparam int CTR_W = 8;
    localparam int LUT_DEPTH = 32;
    localparam int NVEC = 15;

    // {bank[1:0], bit[2:0], drive_stat[11:0], cmd_word[11:0], expected cond_n}
    localparam logic [29:0] VEC [NVEC] = '{
        {2'd0, 3'd5, 12'h001, 12'h000, 1'b0},
        {2'd0, 3'd6, 12'h002, 12'h000, 1'b0},
        {2'd0, 3'd7, 12'h000, 12'h000, 1'b1},
        {2'd0, 3'd4, 12'hFFF, 12'hFFF, 1'b1},
        {2'd1, 3'd0, 12'h008, 12'h000, 1'b0},
        {2'd1, 3'd3, 12'h040, 12'h000, 1'b0},
        {2'd1, 3'd7, 12'h400, 12'h000, 1'b0},
        {2'd1, 3'd4, 12'hF7F, 12'h000, 1'b1},
        {2'd1, 3'd5, 12'h100, 12'h000, 1'b0},
        {2'd1, 3'd6, 12'h200, 12'h000, 1'b0},
        {2'd2, 3'd0, 12'h800, 12'h000, 1'b0},
        {2'd2, 3'd2, 12'hFFF, 12'hFFF, 1'b1},
        {2'd2, 3'd5, 12'h000, 12'h002, 1'b0},
        {2'd3, 3'd0, 12'h000, 12'h010, 1'b0},
        {2'd3, 3'd7, 12'h000, 12'h7FF, 1'b1}
    };

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   uw_valid;
    logic [55:0]            uword;
    logic                   panic_req;
    logic [11:0]            drive_stat;
    logic [11:0]            cmd_word;
    logic [2*LUT_DEPTH-1:0] line_lut;
    logic [3:0]             seq_instr;
    logic [7:0]             seq_data;
    logic                   cond_n;
    logic                   req_b;
    logic [7:0]             host_status;
    logic [CTR_W-1:0]       line_cnt, ed_cnt, head_cnt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dseq_uword_path #(.CTR_W(CTR_W), .LUT_DEPTH(LUT_DEPTH)) u_dseq_uword_path (
        .clk(clk), .rst(rst), .uw_valid(uw_valid), .uword(uword), .panic_req(panic_req),
        .drive_stat(drive_stat), .cmd_word(cmd_word), .line_lut(line_lut),
        .seq_instr(seq_instr), .seq_data(seq_data), .cond_n(cond_n), .req_b(req_b),
        .host_status(host_status), .line_cnt(line_cnt), .ed_cnt(ed_cnt), .head_cnt(head_cnt)
    );

    function automatic logic [55:0] mk(input logic [7:0] b0, b1, b2, b3, b6);
        return {b6, 8'h00, 8'h00, b3, b2, b1, b0};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [55:0] w);
        uword = w;
        uw_valid = 1'b1;
        @(negedge clk);
        uw_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; uw_valid = 1'b0; uword = '0; panic_req = 1'b0;
        drive_stat = '0; cmd_word = '0;
        for (int i = 0; i < LUT_DEPTH; i++) line_lut[2*i +: 2] = 2'(i * 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        chk("R9", "line_cnt", line_cnt, 0);
        chk("R9", "ed_cnt", ed_cnt, 0);
        chk("R9", "head_cnt", head_cnt, 0);
        chk("R9", "seq_instr", seq_instr, 0);
        chk("R9", "seq_data", seq_data, 0);
        chk("R9", "req_b", req_b, 1);
        chk("R8", "status at reset", host_status, 0);
        chk("R5", "cond_n at reset", cond_n, 1);

        // condition table (counters held at 0, lut entry 0 = 0)
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] bk;
            logic [2:0] bt;
            bk = VEC[v][29:28];
            bt = VEC[v][27:25];
            drive_stat = VEC[v][24:13];
            cmd_word = VEC[v][12:1];
            step(mk(8'h00, {bk[0], bt, 4'h0}, {7'b0, bk[1]}, 8'h00, 8'h00));
            chk(bk == 2'd0 ? "R5" : "R6", $sformatf("cond vec %0d", v), cond_n, VEC[v][0]);
        end
        drive_stat = '0; cmd_word = '0;
        chk("R3", "no counter moved by table", {line_cnt, ed_cnt, head_cnt}, 0);

        // R1 data and instruction fields
        step(mk(8'hA5, 8'h3C, 8'h00, 8'h00, 8'h00));
        chk("R1", "seq_data", seq_data, 8'hA5);
        chk("R1", "seq_instr", seq_instr, 4'hC);

        // R3 line counter edges
        step(mk(0, 0, 8'h02, 0, 0));
        chk("R3", "line first rise", line_cnt, 1);
        step(mk(0, 0, 8'h02, 0, 0));
        chk("R3", "line held high ignored", line_cnt, 1);
        step(mk(0, 0, 8'h00, 0, 0));
        chk("R3", "line fall ignored", line_cnt, 1);
        repeat (3) @(negedge clk);
        chk("R3", "line idle", line_cnt, 1);
        step(mk(0, 0, 8'h02, 0, 0));
        chk("R3", "line second rise", line_cnt, 2);

        // R5 lookup entry 2 = 2'b10
        step(mk(0, 8'h10, 8'h00, 0, 0));
        chk("R5", "lut bit1", cond_n, 0);
        step(mk(0, 8'h00, 8'h00, 0, 0));
        chk("R5", "lut bit0", cond_n, 1);

        // R4 clear beats clock
        step(mk(0, 0, 8'h06, 0, 0));
        chk("R4", "line clear with clock", line_cnt, 0);
        step(mk(0, 0, 8'h00, 0, 0));
        step(mk(0, 0, 8'h06, 0, 0));
        chk("R4", "line clear on rise", line_cnt, 0);
        step(mk(0, 0, 8'h00, 0, 0));

        // ED counter to 3, status packing
        for (int i = 0; i < 3; i++) begin
            step(mk(0, 0, 8'h08, 0, 0));
            step(mk(0, 0, 8'h00, 0, 0));
        end
        chk("R3", "ed count", ed_cnt, 3);
        drive_stat = 12'h083;
        step(mk(0, 0, 8'h00, 0, 8'h05));
        chk("R8", "status full", host_status, 8'hFD);
        drive_stat = 12'h000;
        #1;
        chk("R8", "status flags low", host_status, 8'h65);
        step(mk(0, 0, 8'h08, 0, 0));
        chk("R3", "ed to 4", ed_cnt, 4);
        chk("R8", "status ed low bits", host_status, 8'h00);
        step(mk(0, 8'h20, 8'h00, 0, 0));
        chk("R5", "ed bit2 selected", cond_n, 0);

        // head counter, bit 0 on bank 0 bit 3
        step(mk(0, 8'h30, 8'h20, 0, 0));
        chk("R3", "head rise", head_cnt, 1);
        chk("R5", "head bit0 selected", cond_n, 0);
        step(mk(0, 0, 8'h40, 0, 0));
        chk("R4", "head clear", head_cnt, 0);
        for (int i = 0; i < 256; i++) begin
            step(mk(0, 0, 8'h20, 0, 0));
            step(mk(0, 0, 8'h00, 0, 0));
            if (i == 254) chk("R3", "head at 255", head_cnt, 255);
        end
        chk("R3", "head wrap", head_cnt, 0);
        chk("R3", "ed untouched", ed_cnt, 4);

        // R7 end of program
        step(mk(0, 0, 0, 8'h02, 0));
        chk("R7", "req_b at end", req_b, 0);
        step(mk(0, 0, 0, 8'hFD, 0));
        chk("R7", "req_b other bits", req_b, 1);

        // R2 panic forcing
        step(mk(0, 8'h0C, 0, 0, 0));
        chk("R1", "instr before panic", seq_instr, 4'hC);
        panic_req = 1'b1;
        @(negedge clk);
        panic_req = 1'b0;
        chk("R2", "forced after request", seq_instr, 0);
        repeat (2) @(negedge clk);
        chk("R2", "forced while idle", seq_instr, 0);
        panic_req = 1'b1;
        step(mk(0, 8'h07, 0, 0, 0));
        panic_req = 1'b0;
        chk("R2", "request with word keeps forcing", seq_instr, 0);
        step(mk(0, 8'h09, 0, 0, 0));
        chk("R2", "released by accepted word", seq_instr, 4'h9);

        // R9 reset mid-run
        step(mk(8'h5A, 8'h0E, 8'h02, 8'h02, 0));
        chk("R3", "line before reset", line_cnt, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "line after reset", line_cnt, 0);
        chk("R9", "data after reset", seq_data, 0);
        chk("R9", "instr after reset", seq_instr, 0);
        chk("R9", "req_b after reset", req_b, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule